// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block holds the configuration words for a PWM/dead-time unit behind a software lock. Four of its registers are protected: fault handling, dead-time control, dead-time timing and output routing. Extra general-purpose registers sit beside them and are never protected. A lock register decides whether writes to the protected set take effect. A write to the lock register that carries the 16-bit unlock key opens the bank. A write of any other value closes it, so a stray or corrupted write leaves the bank protected instead of exposing it.

Software reaches the block through a simple synchronous interface: one address, a write strobe with write data, and a read strobe whose data comes back one cycle later with a valid flag. Every stored configuration word drives an output port straight from its flop, so the datapath sees a change on the cycle after the write edge. Reading the lock register shows whether the bank is locked.

Top module: `cfg_guard_bank`

## Requirements
- R1: Synchronous active-high reset clears the lock (bank unlocked, `lock_active` = 0), sets every stored register to zero and drives `rd_valid` and `rd_data` low.
- R2: A write to address 4 (lock register) whose low 16 bits equal 0xCE80 unlocks the bank from the next cycle. Bits above bit 15 are ignored by the key comparison.
- R3: A write to address 4 whose low 16 bits differ from 0xCE80 locks the bank from the next cycle, and a locked bank stays locked. A key write to an already unlocked bank leaves it unlocked.
- R4: A read of address 4 returns 1 in bit 0 when the bank is locked and 0 when it is unlocked. All other bits read as 0.
- R5: With the bank unlocked, a write to a protected address updates that register: address 0 fault configuration, 1 dead-time control, 2 dead-time timing, 3 output routing. The new value is visible on its output port and by read from the cycle after the write edge.
- R6: With the bank locked, writes to addresses 0 to 3 are discarded. Their output ports and read-back values keep their previous contents.
- R7: With the bank locked, reads of addresses 0 to 3 still return the current stored values.
- R8: The open registers at addresses 5 to 5+NUM_OPEN-1 (5 and 6 by default) accept writes whether or not the bank is locked. They drive `cfg_open`, with the register at address 5+k in slice k.
- R9: A read strobe at a clock edge presents `rd_data` with `rd_valid` = 1 after that edge, for exactly one cycle per strobe. A read and a write to the same address in the same cycle return the value held before the write.
- R10: Addresses not listed above read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (4) | Register address for the read or write |
| wr_data | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, registered |
| rd_valid | output | 1 | High for one cycle after each read strobe |
| lock_active | output | 1 | Current lock state |
| cfg_fault | output | DATA_W (32) | Fault configuration word |
| cfg_dtctrl | output | DATA_W (32) | Dead-time control word |
| cfg_dttime | output | DATA_W (32) | Dead-time timing word |
| cfg_route | output | DATA_W (32) | Output routing word |
| cfg_open | output | NUM_OPEN*DATA_W (64) | Unprotected registers, flattened |

## Verification
The bench checks that near-miss keys such as 0xCE81 and 0x0000 lock the bank. A design that compared only some key bits, or that toggled the lock on each write, would leave the bank open. It also checks that a key carried with nonzero upper bits still unlocks, which catches a full-width comparison. Writes to protected registers while locked are checked both by read-back and at the output ports, so gating that protected only the read path would show up. The bench also covers open registers while locked, reads of unmapped addresses, a read in the same cycle as a write (a bypassing read port would return the new value), and a reset in mid-operation that must reopen the bank and clear every register.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
  // Number of lock-protected registers and their slot order.
  localparam int N_PROT      = 4;
  localparam int SLOT_FAULT  = 0;
  localparam int SLOT_DTCTRL = 1;
  localparam int SLOT_DTTIME = 2;
  localparam int SLOT_ROUTE  = 3;
  // Lock register sits just after the protected set; open registers follow.
  localparam int ADDR_LOCK   = N_PROT;
  localparam int OPEN_BASE   = N_PROT + 1;

  // Bus address of a storage slot.
  function automatic int slot_addr(input int slot);
    return (slot < N_PROT) ? slot : slot + 1;
  endfunction
endpackage

// File: rtl/cfgb_lock_ctrl.sv
module cfgb_lock_ctrl #(
  parameter int          KEY_W = 16,
  parameter logic [15:0] KEY   = 16'hCE80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_wr,
  input  logic [KEY_W-1:0] key_in,
  output logic             locked
);
  logic key_match;

  assign key_match = (key_in == KEY_W'(KEY));

  always_ff @(posedge clk) begin
    if (rst)          locked <= 1'b0;
    else if (lock_wr) locked <= !key_match;
  end

  // R1
  reset_unlock_chk: assert property (@(posedge clk) rst |=> !locked)
    else $error("lock not cleared by reset");
  // R2
  key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && key_in == KEY_W'(KEY)) |=> !locked)
    else $error("key write did not unlock");
  // R3
  bad_key_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_wr && key_in != KEY_W'(KEY)) |=> locked)
    else $error("non-key write did not lock");
  // R3
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_wr |=> $stable(locked))
    else $error("lock changed without a lock write");
endmodule

// File: rtl/cfgb_reg_slot.sv
module cfgb_reg_slot #(
  parameter int DATA_W    = 32,
  parameter bit PROTECTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic wr_ok;

  generate
    if (PROTECTED) begin : g_guarded
      assign wr_ok = wr_hit && !locked;
      // R6
      locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(q))
        else $error("protected register changed while locked");
      // R5
      open_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !locked) |=> (q == $past(wdata)))
        else $error("unlocked write not stored");
    end else begin : g_free
      assign wr_ok = wr_hit;
      // R8
      free_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (q == $past(wdata)))
        else $error("open register write not stored");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_ok) q <= wdata;
  end

  // R1
  slot_reset_chk: assert property (@(posedge clk) rst |=> (q == '0))
    else $error("register not cleared by reset");
  // R10
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(q))
    else $error("register changed without an address hit");
endmodule

// File: rtl/cfgb_read_port.sv
module cfgb_read_port
  import cfgbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       locked,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_LOCK)) rd_next = DATA_W'(locked);
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(slot_addr(i))) rd_next = regs_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid)
    else $error("read strobe without valid");
  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid)
    else $error("valid without read strobe");
  // R4
  lock_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(ADDR_LOCK)) |=> (rd_data == DATA_W'($past(locked))))
    else $error("lock read mismatch");
endmodule

// File: rtl/cfg_guard_bank.sv
module cfg_guard_bank
  import cfgbank_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int          NUM_OPEN = 2,
  parameter int          KEY_W    = 16,
  parameter logic [15:0] KEY      = 16'hCE80
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic                       lock_active,
  output logic [DATA_W-1:0]          cfg_fault,
  output logic [DATA_W-1:0]          cfg_dtctrl,
  output logic [DATA_W-1:0]          cfg_dttime,
  output logic [DATA_W-1:0]          cfg_route,
  output logic [NUM_OPEN*DATA_W-1:0] cfg_open
);
  localparam int NUM_REGS = N_PROT + NUM_OPEN;

  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  logic                       locked;
  logic                       lock_wr;

  assign lock_wr = wr_en && (addr == ADDR_W'(ADDR_LOCK));

  cfgb_lock_ctrl #(.KEY_W(KEY_W), .KEY(KEY)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .lock_wr(lock_wr),
    .key_in (wr_data[KEY_W-1:0]),
    .locked (locked)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(slot_addr(i)));
    cfgb_reg_slot #(.DATA_W(DATA_W), .PROTECTED(i < N_PROT)) u_slot (
      .clk   (clk),
      .rst   (rst),
      .wr_hit(hit),
      .locked(locked),
      .wdata (wr_data),
      .q     (regs_flat[i*DATA_W +: DATA_W])
    );
  end

  cfgb_read_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .addr     (addr),
    .locked   (locked),
    .regs_flat(regs_flat),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  assign lock_active = locked;
  assign cfg_fault   = regs_flat[SLOT_FAULT*DATA_W  +: DATA_W];
  assign cfg_dtctrl  = regs_flat[SLOT_DTCTRL*DATA_W +: DATA_W];
  assign cfg_dttime  = regs_flat[SLOT_DTTIME*DATA_W +: DATA_W];
  assign cfg_route   = regs_flat[SLOT_ROUTE*DATA_W  +: DATA_W];
  assign cfg_open    = regs_flat[NUM_REGS*DATA_W-1 : N_PROT*DATA_W];
endmodule

// File: tb/tb_cfg_guard_bank.sv
`timescale 1ns/1ps
module tb_cfg_guard_bank;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst, wr_en, rd_en;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_valid, lock_active;
  logic [DW-1:0] cfg_fault, cfg_dtctrl, cfg_dttime, cfg_route;
  logic [NO*DW-1:0] cfg_open;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  always #5 clk = ~clk;

  cfg_guard_bank #(.DATA_W(DW), .ADDR_W(AW), .NUM_OPEN(NO)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .lock_active(lock_active), .cfg_fault(cfg_fault), .cfg_dtctrl(cfg_dtctrl),
    .cfg_dttime(cfg_dttime), .cfg_route(cfg_route), .cfg_open(cfg_open)
  );

  // Vector: {is_read, addr, data, expected, requirement number}
  localparam int NV = 34;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 4'd0, 32'h11,        32'h0,  8'd5},
    {1'b1, 4'd0, 32'h0,         32'h11, 8'd5},  // R5
    {1'b0, 4'd1, 32'h22,        32'h0,  8'd5},
    {1'b0, 4'd2, 32'h33,        32'h0,  8'd5},
    {1'b0, 4'd3, 32'h44,        32'h0,  8'd5},
    {1'b1, 4'd1, 32'h0,         32'h22, 8'd5},
    {1'b1, 4'd2, 32'h0,         32'h33, 8'd5},
    {1'b1, 4'd3, 32'h0,         32'h44, 8'd5},
    {1'b1, 4'd4, 32'h0,         32'h0,  8'd4},  // R4 unlocked reads 0
    {1'b0, 4'd4, 32'h1234,      32'h0,  8'd3},
    {1'b1, 4'd4, 32'h0,         32'h1,  8'd3},  // R3 locked
    {1'b0, 4'd0, 32'hAA,        32'h0,  8'd6},
    {1'b1, 4'd0, 32'h0,         32'h11, 8'd6},  // R6 discarded
    {1'b0, 4'd3, 32'hBB,        32'h0,  8'd7},
    {1'b1, 4'd3, 32'h0,         32'h44, 8'd7},  // R7 read while locked
    {1'b0, 4'd5, 32'h55,        32'h0,  8'd8},
    {1'b1, 4'd5, 32'h0,         32'h55, 8'd8},  // R8 open while locked
    {1'b0, 4'd6, 32'h66,        32'h0,  8'd8},
    {1'b1, 4'd6, 32'h0,         32'h66, 8'd8},
    {1'b0, 4'd4, 32'hFFFF_CE80, 32'h0,  8'd2},
    {1'b1, 4'd4, 32'h0,         32'h0,  8'd2},  // R2 upper bits ignored
    {1'b0, 4'd0, 32'hAA,        32'h0,  8'd5},
    {1'b1, 4'd0, 32'h0,         32'hAA, 8'd5},
    {1'b0, 4'd4, 32'hCE81,      32'h0,  8'd3},
    {1'b1, 4'd4, 32'h0,         32'h1,  8'd3},  // R3 near-miss key
    {1'b0, 4'd4, 32'h0,         32'h0,  8'd3},
    {1'b1, 4'd4, 32'h0,         32'h1,  8'd3},  // R3 stays locked
    {1'b0, 4'd4, 32'hCE80,      32'h0,  8'd3},
    {1'b0, 4'd4, 32'hCE80,      32'h0,  8'd3},
    {1'b1, 4'd4, 32'h0,         32'h0,  8'd3},  // R3 key twice stays open
    {1'b1, 4'd7, 32'h0,         32'h0,  8'd10}, // R10 unmapped
    {1'b0, 4'd9, 32'h99,        32'h0,  8'd10},
    {1'b1, 4'd9, 32'h0,         32'h0,  8'd10},
    {1'b1, 4'd15, 32'h0,        32'h0,  8'd10}
  };

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check({tag, " rd_valid"}, DW'(rd_valid), 1);
    check({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lock_active", DW'(lock_active), 0);
    check("R1 rd_valid", DW'(rd_valid), 0);
    check("R1 cfg_fault", cfg_fault, 0);
    check("R1 cfg_route", cfg_route, 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][76])
        do_read(VEC[v][75:72], VEC[v][39:8], $sformatf("R%0d vec%0d", VEC[v][7:0], v));
      else
        do_write(VEC[v][75:72], VEC[v][71:40]);
    end

    // R6 locked writes leave the output ports unchanged
    do_write(4'd4, 32'h0000_0001);
    check("R3 lock_active port", DW'(lock_active), 1);
    do_write(4'd1, 32'hDEAD);
    do_write(4'd2, 32'hBEEF);
    do_write(4'd3, 32'hCAFE);
    do_write(4'd0, 32'hF00D);
    check("R6 cfg_fault", cfg_fault, 32'hAA);
    check("R6 cfg_dtctrl", cfg_dtctrl, 32'h22);
    check("R6 cfg_dttime", cfg_dttime, 32'h33);
    check("R6 cfg_route", cfg_route, 32'h44);
    // R8 open registers on port while locked
    do_write(4'd6, 32'h7777);
    check("R8 cfg_open hi", cfg_open[2*DW-1:DW], 32'h7777);
    check("R8 cfg_open lo", cfg_open[DW-1:0], 32'h55);

    // R9 read and write in the same cycle return the old value
    do_write(4'd4, 32'hCE80);
    check("R2 lock_active port", DW'(lock_active), 0);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 4'd0; wr_data = 32'h77;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check("R9 same-cycle rd_data", rd_data, 32'hAA);
    check("R5 cfg_fault updated", cfg_fault, 32'h77);
    @(negedge clk);
    check("R9 rd_valid drops", DW'(rd_valid), 0);
    do_read(4'd0, 32'h77, "R9 follow-up read");

    // R1 reset in mid-operation while locked
    do_write(4'd4, 32'h5);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 lock cleared", DW'(lock_active), 0);
    check("R1 cfg_dtctrl cleared", cfg_dtctrl, 0);
    check("R1 cfg_open cleared", cfg_open[DW-1:0], 0);
    do_read(4'd3, 32'h0, "R1 readback");

    report();
  end
endmodule